// File: doc/BRIEF.md
# Sync-Triggered Bit Capture Buffer

This block records a raw serial bit stream into an on-chip byte memory. Bits arrive on an external bit clock that has no fixed relation to the system clock. They are synchronised into the system clock domain and packed into bytes. Recording begins only when two things have happened: software has armed the block, and then a rising edge appears on an external sync line. That sync line pulses on a slow periodic timebase, so it also sets the fastest rate at which the memory can be refilled. Recording stops once the last address has been written. The block then holds the image so that a download sequencer can read it through a registered byte read port.

A second fill mode writes one of thirteen built-in test patterns into the memory. The pattern bits are paced by the same external bit clock, so the path from the bit clock to the memory is exercised without any real data source. Three status outputs report the block's phase: armed and waiting for sync, taking data, or holding a full image.

The memory holds 2**ADDR_W bytes. ADDR_W = 17 gives the full one-megabit (128 KB) buffer. The default value is smaller so that elaboration stays light.

Top module: `capture_buffer`

## Requirements
- R1: Once reset has been released, `armed_o`, `taking_o` and `holding_o` are all low.
- R2: A one-cycle `cmd_arm` pulse puts the block in the armed state, and `armed_o` goes high on the following cycle. A `cmd_disarm` pulse while armed returns the block to idle, with all status outputs low.
- R3: A rising edge on `sync_in` has no effect while the block is not armed. `taking_o` stays low, and bit clock edges write nothing.
- R4: A rising edge on `sync_in` while armed starts a capture at address 0. `armed_o` falls and `taking_o` rises.
- R5: While capturing, `bit_data` is sampled on each rising edge of `bit_clk`. Every eight bits form one byte, with the first bit in bit 7. Each completed byte is written at the current address, and the address then advances by one.
- R6: When the byte at address 2**ADDR_W-1 has been written, `taking_o` falls and `holding_o` rises.
- R7: While holding, further bit clock edges and sync edges are ignored. The memory image and `holding_o` do not change until an arm or a valid pattern load arrives.
- R8: A `cmd_load` pulse with `pat_sel` in the range 0x0 to 0xC starts a pattern fill from any state, and it takes priority over `cmd_arm`. `taking_o` is high during the fill. The byte written at address k is given by `pat_sel` as follows (kk is the low 8 bits of k): 0 gives 0x00; 1 gives 0xFF; 2 gives 0x55; 3 gives 0xAA; 4 gives 0x33; 5 gives 0x0F; 6 gives 0xAA if kk bit 1 is set, otherwise 0x55; 7 gives kk; 8 gives the inverse of kk; 9 gives 0xFF if kk bit 0 is set, otherwise 0x00; A gives 0x01 shifted left by kk[2:0]; B gives the inverse of that value; C gives kk XOR 0xA5. A fill ends in the hold state, as described in R6.
- R9: With pattern selector 6, the memory reads 0x55, 0x55, 0xAA, 0xAA, and the sequence repeats from there.
- R10: A pattern fill advances only on rising edges of `bit_clk`, one bit per edge. With no bit clock, nothing is written and `taking_o` stays high.
- R11: A `cmd_load` with `pat_sel` from 0xD to 0xF is ignored. The state and the memory image are left unchanged.
- R12: While holding, `cmd_arm` brings the block back to the armed state, ready for the next sync edge.
- R13: `rd_data` returns the byte stored at `rd_addr` one clock cycle after `rd_addr` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bit_clk | input | 1 | External bit clock; each rising edge carries one bit |
| bit_data | input | 1 | Serial raw data bit, held stable around the bit clock rising edge |
| sync_in | input | 1 | External sync line; a rising edge starts an armed capture |
| cmd_arm | input | 1 | One-cycle request to arm |
| cmd_disarm | input | 1 | One-cycle request to leave the armed state |
| cmd_load | input | 1 | One-cycle request to start a pattern fill |
| pat_sel | input | 4 | Pattern selector, sampled with `cmd_load` |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Byte at the read address, one cycle later |
| armed_o | output | 1 | Armed and waiting for sync |
| taking_o | output | 1 | Capture or pattern fill in progress |
| holding_o | output | 1 | Memory full, image held |

## Verification
The hardest condition to reach from the ports is proving that something was not written. Examples are a sync edge that arrives while idle, bits that arrive after the image is full, a pattern load with no bit clock, and an out-of-range selector. The memory has no reset value, so none of these can be judged from the memory on its own. The stimulus therefore first fills the memory with a known captured image. Each ignored event is applied after that, and the bench reads back through the read port to confirm that the earlier bytes are still present. The 0x55/0xAA sequence is then clocked in bit by bit through the external bit clock, so the fill, the byte packing and the addressing are all checked through the real synchroniser path.

// File: rtl/cbuf_pkg.sv
package cbuf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_CAPT  = 3'd2,
    ST_LOAD  = 3'd3,
    ST_HOLD  = 3'd4
  } cbuf_state_e;

  // highest valid pattern selector
  localparam logic [3:0] PAT_LAST = 4'hC;

  function automatic logic [7:0] pat_byte(input logic [3:0] sel, input logic [7:0] k);
    logic [7:0] walk;
    walk = 8'h01 << k[2:0];
    case (sel)
      4'h0:    pat_byte = 8'h00;
      4'h1:    pat_byte = 8'hFF;
      4'h2:    pat_byte = 8'h55;
      4'h3:    pat_byte = 8'hAA;
      4'h4:    pat_byte = 8'h33;
      4'h5:    pat_byte = 8'h0F;
      4'h6:    pat_byte = k[1] ? 8'hAA : 8'h55;
      4'h7:    pat_byte = k;
      4'h8:    pat_byte = ~k;
      4'h9:    pat_byte = k[0] ? 8'hFF : 8'h00;
      4'hA:    pat_byte = walk;
      4'hB:    pat_byte = ~walk;
      4'hC:    pat_byte = k ^ 8'hA5;
      default: pat_byte = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cbuf_sync.sv
module cbuf_sync #(
  parameter int STAGES = 2,
  parameter bit EDGE   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic out_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_i};
      last_q  <= chain_q[STAGES-1];
    end
  end

  generate
    if (EDGE) begin : g_edge
      assign out_o = chain_q[STAGES-1] & ~last_q;
    end else begin : g_level
      assign out_o = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/cbuf_ctrl.sv
module cbuf_ctrl
  import cbuf_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              bit_val,
  input  logic              sync_stb,
  input  logic              cmd_arm,
  input  logic              cmd_disarm,
  input  logic              cmd_load,
  input  logic [3:0]        pat_sel,
  output cbuf_state_e       state_o,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

  cbuf_state_e       state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [2:0]        bcnt_q, bcnt_d;
  logic [7:0]        shreg_q, shreg_d;
  logic [3:0]        sel_q, sel_d;

  logic [7:0] pbyte, shift_w;
  logic       bit_in, load_ok, restart, filling, take_bit, byte_done;

  always_comb begin
    pbyte     = pat_byte(sel_q, 8'(addr_q));
    bit_in    = (state_q == ST_LOAD) ? pbyte[3'd7 - bcnt_q] : bit_val;
    shift_w   = {shreg_q[6:0], bit_in};
    load_ok   = cmd_load && (pat_sel <= PAT_LAST);
    restart   = load_ok || cmd_arm;
    filling   = (state_q == ST_CAPT) || (state_q == ST_LOAD);
    take_bit  = filling && bit_stb && !restart;
    byte_done = take_bit && (bcnt_q == 3'd7);

    state_d = state_q;
    addr_d  = addr_q;
    bcnt_d  = bcnt_q;
    shreg_d = shreg_q;
    sel_d   = sel_q;

    if (load_ok) begin
      state_d = ST_LOAD;
      sel_d   = pat_sel;
      addr_d  = '0;
      bcnt_d  = '0;
    end else if (cmd_arm) begin
      state_d = ST_ARMED;
      addr_d  = '0;
      bcnt_d  = '0;
    end else begin
      case (state_q)
        ST_ARMED: begin
          if (cmd_disarm) begin
            state_d = ST_IDLE;
          end else if (sync_stb) begin
            state_d = ST_CAPT;
            addr_d  = '0;
            bcnt_d  = '0;
          end
        end
        ST_CAPT, ST_LOAD: begin
          if (take_bit) begin
            shreg_d = shift_w;
            bcnt_d  = bcnt_q + 3'd1;
            if (byte_done) begin
              addr_d = addr_q + 1'b1;
              if (addr_q == LAST_ADDR) state_d = ST_HOLD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      bcnt_q  <= '0;
      shreg_q <= '0;
      sel_q   <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      bcnt_q  <= bcnt_d;
      shreg_q <= shreg_d;
      sel_q   <= sel_d;
    end
  end

  assign state_o = state_q;
  assign wr_en   = byte_done;
  assign wr_addr = addr_q;
  assign wr_data = shift_w;
endmodule

// File: rtl/cbuf_mem.sv
module cbuf_mem #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] store [DEPTH];
  logic [7:0] rd_q;

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
    rd_q <= store[rd_addr];
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/capture_buffer.sv
module capture_buffer
  import cbuf_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_clk,
  input  logic              bit_data,
  input  logic              sync_in,
  input  logic              cmd_arm,
  input  logic              cmd_disarm,
  input  logic              cmd_load,
  input  logic [3:0]        pat_sel,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              armed_o,
  output logic              taking_o,
  output logic              holding_o
);
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic bit_stb, bit_val, sync_stb;

  cbuf_sync #(.STAGES(SYNC_STAGES), .EDGE(1'b1)) u_bclk (
    .clk(clk), .rst_n(rst_int_n), .async_i(bit_clk), .out_o(bit_stb));
  cbuf_sync #(.STAGES(SYNC_STAGES), .EDGE(1'b0)) u_bdat (
    .clk(clk), .rst_n(rst_int_n), .async_i(bit_data), .out_o(bit_val));
  cbuf_sync #(.STAGES(SYNC_STAGES), .EDGE(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .async_i(sync_in), .out_o(sync_stb));

  cbuf_state_e       state;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;

  cbuf_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .bit_stb(bit_stb), .bit_val(bit_val),
    .sync_stb(sync_stb), .cmd_arm(cmd_arm), .cmd_disarm(cmd_disarm),
    .cmd_load(cmd_load), .pat_sel(pat_sel), .state_o(state),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

  cbuf_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data));

  assign armed_o   = (state == ST_ARMED);
  assign taking_o  = (state == ST_CAPT) || (state == ST_LOAD);
  assign holding_o = (state == ST_HOLD);
endmodule

// File: rtl/capture_buffer_chk.sv
module capture_buffer_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_arm,
  input logic cmd_disarm,
  input logic cmd_load,
  input logic armed_o,
  input logic taking_o,
  input logic holding_o,
  input logic wr_en
);
  // R1
  status_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({armed_o, taking_o, holding_o}));

  // R2
  arm_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_arm && !cmd_load |=> armed_o);

  // R2
  disarm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_o && cmd_disarm && !cmd_arm && !cmd_load |=> !armed_o && !taking_o);

  // R3
  idle_sync_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_o && !taking_o && !cmd_arm && !cmd_load |=> !taking_o);

  // R6
  hold_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(holding_o) |-> $past(wr_en));

  // R7
  hold_persists_chk: assert property (@(posedge clk) disable iff (!rst_n)
    holding_o && !cmd_arm && !cmd_load |=> holding_o);

  // R10
  write_only_filling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> taking_o);
endmodule

bind capture_buffer capture_buffer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_arm(cmd_arm), .cmd_disarm(cmd_disarm),
  .cmd_load(cmd_load), .armed_o(armed_o), .taking_o(taking_o),
  .holding_o(holding_o), .wr_en(wr_en));

// File: tb/capture_buffer_test.sv
`timescale 1ns/1ps
module capture_buffer_test;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_clk = 1'b0, bit_data = 1'b0, sync_in = 1'b0;
  logic cmd_arm = 1'b0, cmd_disarm = 1'b0, cmd_load = 1'b0;
  logic [3:0] pat_sel = 4'h0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic armed_o, taking_o, holding_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  int    q_addr[$];
  int    q_data[$];
  string q_tag[$];
  logic [7:0] cap_img [DEPTH];

  always #2 clk = ~clk;

  capture_buffer #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .bit_data(bit_data),
    .sync_in(sync_in), .cmd_arm(cmd_arm), .cmd_disarm(cmd_disarm),
    .cmd_load(cmd_load), .pat_sel(pat_sel), .rd_addr(rd_addr),
    .rd_data(rd_data), .armed_o(armed_o), .taking_o(taking_o),
    .holding_o(holding_o));

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic status(input string tag, input logic a, input logic t, input logic h);
    check(tag, {29'd0, armed_o, taking_o, holding_o}, {29'd0, a, t, h});
  endtask

  // driver side of the scoreboard
  task automatic push_exp(input int a, input int d, input string tag);
    q_addr.push_back(a);
    q_data.push_back(d);
    q_tag.push_back(tag);
  endtask

  // monitor side: read each expected address back through the port (R13)
  task automatic drain();
    while (q_addr.size() > 0) begin
      int a = q_addr.pop_front();
      int d = q_data.pop_front();
      string t = q_tag.pop_front();
      @(negedge clk) rd_addr = AW'(a);
      @(negedge clk);
      check({t, " R13"}, int'(rd_data), d);
    end
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: cmd_arm = 1'b1;
      1: cmd_disarm = 1'b1;
      default: cmd_load = 1'b1;
    endcase
    @(negedge clk);
    cmd_arm = 1'b0; cmd_disarm = 1'b0; cmd_load = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk) bit_data = b;
    repeat (2) @(negedge clk);
    bit_clk = 1'b1;
    repeat (3) @(negedge clk);
    bit_clk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic sync_pulse();
    @(negedge clk) sync_in = 1'b1;
    repeat (3) @(negedge clk);
    sync_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [7:0] pat_ref(input int sel, input int k);
    logic [7:0] kk = 8'(k);
    case (sel)
      6: return kk[1] ? 8'hAA : 8'h55;
      7: return kk;
      10: return 8'h01 << kk[2:0];
      default: return 8'h00;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    status("R1 reset", 0, 0, 0);

    // R3: sync with nothing armed
    sync_pulse();
    send_byte(8'hC3);
    status("R3 sync while idle", 0, 0, 0);

    // R2 arm / disarm
    pulse(0);
    status("R2 armed", 1, 0, 0);
    pulse(1);
    status("R2 disarmed", 0, 0, 0);
    pulse(0);

    // R4 capture starts on sync
    sync_pulse();
    status("R4 taking after sync", 0, 1, 0);
    for (int i = 0; i < DEPTH; i++) begin
      cap_img[i] = 8'(i * 37 + 11);
      send_byte(cap_img[i]);
      if (i == DEPTH - 2) status("R6 not full yet", 0, 1, 0);
    end
    status("R6 hold when full", 0, 0, 1);
    for (int i = 0; i < DEPTH; i++) push_exp(i, cap_img[i], "R5 capture byte");
    drain();

    // R7 bits and sync after hold are ignored
    send_byte(8'hFF);
    sync_pulse();
    send_byte(8'h00);
    status("R7 still holding", 0, 0, 1);
    push_exp(0, cap_img[0], "R7 image kept");
    push_exp(1, cap_img[1], "R7 image kept");
    drain();

    // R11 invalid selector ignored
    @(negedge clk) pat_sel = 4'hD;
    pulse(2);
    send_byte(8'h81);
    status("R11 bad selector", 0, 0, 1);
    push_exp(0, cap_img[0], "R11 image kept");
    drain();

    // R10 load with no bit clock writes nothing
    @(negedge clk) pat_sel = 4'h6;
    pulse(2);
    repeat (300) @(negedge clk);
    status("R10 waiting for bit clock", 0, 1, 0);
    push_exp(0, cap_img[0], "R10 no write");
    push_exp(3, cap_img[3], "R10 no write");
    drain();

    // R9 pattern 6 through the bit clock
    for (int i = 0; i < DEPTH * 8; i++) send_bit(1'b0);
    status("R8 pattern fill holds", 0, 0, 1);
    for (int i = 0; i < DEPTH; i++) push_exp(i, pat_ref(6, i), "R9 pattern 6");
    drain();

    // R8 ramp and walking-one patterns, load from armed state
    pulse(0);
    status("R12 re-armed from hold", 1, 0, 0);
    @(negedge clk) pat_sel = 4'h7;
    pulse(2);
    status("R8 load taking", 0, 1, 0);
    for (int i = 0; i < DEPTH * 8; i++) send_bit(1'b1);
    for (int i = 0; i < DEPTH; i++) push_exp(i, pat_ref(7, i), "R8 pattern 7");
    drain();

    @(negedge clk) pat_sel = 4'hA;
    pulse(2);
    for (int i = 0; i < DEPTH * 8; i++) send_bit(1'b0);
    for (int i = 0; i < DEPTH; i++) push_exp(i, pat_ref(10, i), "R8 pattern A");
    drain();

    // R12 re-arm from hold and capture again
    pulse(0);
    sync_pulse();
    status("R12 second capture", 0, 1, 0);
    for (int i = 0; i < DEPTH; i++) send_byte(8'(255 - i));
    status("R12 second hold", 0, 0, 1);
    push_exp(0, 255, "R12 recapture");
    push_exp(DEPTH - 1, 255 - (DEPTH - 1), "R12 recapture");
    drain();

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule